// File: doc/BRIEF.md
# SEC-DED Protected Data Port

This block sits on a 32-bit data port that carries words both to and from local memory and to and from neighbouring nodes. The same code protects both kinds of traffic. On the outgoing side it adds seven check bits to each word: six Hamming parity bits and one overall parity bit. On the incoming side it recomputes the syndrome combinationally and repairs any single flipped bit, whether that bit is in the data or in the check field. It flags any double-bit error, and some wider errors, as uncorrectable. Both directions accept one word per clock and register their results, so each has one cycle of latency.

Every word that is corrected adds one to a saturating counter. The counter is copied into a readable snapshot register on each cycle in which the synchronous backend reports that it is idle. An uncorrectable word drives a small two-state controller from `RUN` to `HALT`, unless the fatal-error mask is set. In `HALT` the block holds a machine-stop request until reset. The only transition is `RUN` to `HALT`, taken on an unmasked uncorrectable word. `HALT` then stays in `HALT` on every cycle.

Top module: `secded_port`

## Requirements
- R1: One cycle after `tx_valid_i` is high, `tx_valid_o` is high, `tx_data_o` equals the word, and `tx_chk_o` holds its code. The data bits take codeword positions 3, 5, 6, 7, 9, 10 and so on, skipping powers of two, in ascending bit order up to position 38. For k in 0..5, `tx_chk_o[k]` is the XOR of the data bits whose position has bit k set. `tx_chk_o[6]` is the XOR of all 32 data bits and `tx_chk_o[5:0]`.
- R2: One cycle after `rx_valid_i` is high, `rx_valid_o` is high and `rx_data_o`, `rx_corrected_o` and `rx_fatal_o` describe that word.
- R3: A received word whose check bits match its data, as defined in R1, comes out unchanged, with both flags low.
- R4: A received word with exactly one flipped data bit comes out repaired, with `rx_corrected_o` high and `rx_fatal_o` low.
- R5: A received word with exactly one flipped bit among the seven check bits comes out with its data unchanged, with `rx_corrected_o` high.
- R6: A received word with two flipped bits sets `rx_fatal_o`, leaves `rx_corrected_o` low, and passes the received data through unmodified.
- R7: When `err_mask_i` is low, an uncorrectable word raises `halt_req_o` in the same cycle as `rx_fatal_o`. `halt_req_o` then stays high until reset.
- R8: When `err_mask_i` is high, an uncorrectable word still sets `rx_fatal_o` but leaves `halt_req_o` low.
- R9: The corrected-error counter rises by one for each corrected word and stops at 2^CNT_W-1 without wrapping. Clean and uncorrectable words leave it unchanged.
- R10: `corr_count_o` takes the counter value at each clock edge where `backend_idle_i` is high. It holds its value while `backend_idle_i` is low.
- R11: After reset, every output is zero and the controller is in `RUN`.
- R12: While `rx_valid_i` is low, the data on `rx_data_i` and `rx_chk_i` raises no flag and does not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_mask_i | input | 1 | Masks the stop request on uncorrectable errors |
| backend_idle_i | input | 1 | Synchronous section idle; enables the counter snapshot |
| tx_valid_i | input | 1 | Outgoing word valid |
| tx_data_i | input | 32 | Outgoing data word |
| tx_valid_o | output | 1 | Encoded word valid |
| tx_data_o | output | 32 | Encoded data word |
| tx_chk_o | output | 7 | Check bits of the encoded word |
| rx_valid_i | input | 1 | Incoming word valid |
| rx_data_i | input | 32 | Incoming data word |
| rx_chk_i | input | 7 | Incoming check bits |
| rx_valid_o | output | 1 | Decoded word valid |
| rx_data_o | output | 32 | Decoded, repaired data |
| rx_corrected_o | output | 1 | Word had a single error that was corrected |
| rx_fatal_o | output | 1 | Word had an uncorrectable error |
| halt_req_o | output | 1 | Sticky machine-stop request |
| corr_count_o | output | 8 | Snapshot of the corrected-error count |

## Verification
The assertions check several properties on every cycle: the stop request never drops once raised, it rises only together with an uncorrectable flag and only when the mask was clear, and the two flags are never set at once or without a valid word. They also check that the counter moves by at most one and stays put at its maximum, and that the snapshot is frozen while the backend is busy. Only the bench scenarios can show that the check bits match the stated bit positions and that every single-bit position is repaired. The same holds for telling check-bit errors apart from data errors, for double errors passing through unchanged, and for the exact saturation value read back after a long burst.

// File: rtl/secded_pkg.sv
package secded_pkg;

    localparam int MAX_DW = 256;

    typedef enum logic [1:0] {
        DK_CLEAN    = 2'd0,
        DK_FIX_DATA = 2'd1,
        DK_FIX_CHK  = 2'd2,
        DK_FATAL    = 2'd3
    } dec_kind_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } port_state_t;

    // Smallest r with 2^r >= dw + r + 1
    function automatic int unsigned ham_bits(int unsigned dw);
        int unsigned r;
        r = 0;
        for (int unsigned k = 1; k < 16; k++) begin
            if (r == 0 && (32'd1 << k) >= dw + k + 1) r = k;
        end
        return r;
    endfunction

    // Codeword position of data bit idx (positions that are powers of two are skipped)
    function automatic int unsigned code_pos(int unsigned idx, int unsigned hw);
        int unsigned p;
        p = idx + 1;
        for (int unsigned k = 0; k < hw; k++) begin
            if ((32'd1 << k) <= p) p = p + 1;
        end
        return p;
    endfunction

    // Data bits covered by parity bit k
    function automatic logic [MAX_DW-1:0] cover_mask(int unsigned dw, int unsigned hw, int unsigned k);
        logic [MAX_DW-1:0] m;
        m = '0;
        for (int unsigned i = 0; i < dw; i++) begin
            if (((code_pos(i, hw) >> k) & 32'd1) != 32'd0) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_ham.sv
module secded_ham
    import secded_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HAM_W  = ham_bits(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [HAM_W-1:0]  ham_o
);

    for (genvar k = 0; k < HAM_W; k++) begin : g_par
        localparam logic [MAX_DW-1:0] COVER = cover_mask(DATA_W, HAM_W, k);
        assign ham_o[k] = ^(data_i & COVER[DATA_W-1:0]);
    end

endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HAM_W  = ham_bits(DATA_W),
    parameter int CHK_W  = HAM_W + 1
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  chk_i,
    output logic [DATA_W-1:0] fixed_o,
    output dec_kind_t         kind_o
);

    logic [HAM_W-1:0]  ham_calc;
    logic [HAM_W-1:0]  syn;
    logic              par_odd;
    logic [DATA_W-1:0] hit;

    secded_ham #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_reham (
        .data_i (data_i),
        .ham_o  (ham_calc)
    );

    assign syn     = ham_calc ^ chk_i[HAM_W-1:0];
    assign par_odd = (^data_i) ^ (^chk_i);

    for (genvar i = 0; i < DATA_W; i++) begin : g_fix
        localparam int unsigned POS = code_pos(i, HAM_W);
        assign hit[i] = par_odd && (syn == POS[HAM_W-1:0]);
    end

    assign fixed_o = data_i ^ hit;

    always_comb begin
        if (!par_odd && syn == '0)
            kind_o = DK_CLEAN;
        else if (!par_odd)
            kind_o = DK_FATAL;
        else if (syn == '0 || $onehot(syn))
            kind_o = DK_FIX_CHK;
        else if (|hit)
            kind_o = DK_FIX_DATA;
        else
            kind_o = DK_FATAL;
    end

endmodule

// File: rtl/secded_err_cnt.sv
module secded_err_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             idle_i,
    output logic [CNT_W-1:0] snap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (inc_i && cnt_q != CNT_MAX)
            cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_o <= '0;
        else if (idle_i)
            snap_o <= cnt_q;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != $past(cnt_q)) |-> (cnt_q == $past(cnt_q) + 1'b1)); // R9
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R9
    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |=> $stable(snap_o)); // R10

endmodule

// File: rtl/secded_port.sv
module secded_port
    import secded_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8,
    parameter int HAM_W  = ham_bits(DATA_W),
    parameter int CHK_W  = HAM_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_mask_i,
    input  logic              backend_idle_i,
    input  logic              tx_valid_i,
    input  logic [DATA_W-1:0] tx_data_i,
    output logic              tx_valid_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic [CHK_W-1:0]  tx_chk_o,
    input  logic              rx_valid_i,
    input  logic [DATA_W-1:0] rx_data_i,
    input  logic [CHK_W-1:0]  rx_chk_i,
    output logic              rx_valid_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_corrected_o,
    output logic              rx_fatal_o,
    output logic              halt_req_o,
    output logic [CNT_W-1:0]  corr_count_o
);

    // ---------------- outgoing encoder ----------------
    logic [HAM_W-1:0] tx_ham;
    logic [CHK_W-1:0] tx_chk_d;

    secded_ham #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_tx_ham (
        .data_i (tx_data_i),
        .ham_o  (tx_ham)
    );

    assign tx_chk_d = {(^tx_data_i) ^ (^tx_ham), tx_ham};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid_o <= 1'b0;
            tx_data_o  <= '0;
            tx_chk_o   <= '0;
        end else begin
            tx_valid_o <= tx_valid_i;
            if (tx_valid_i) begin
                tx_data_o <= tx_data_i;
                tx_chk_o  <= tx_chk_d;
            end
        end
    end

    // ---------------- incoming decoder ----------------
    logic [DATA_W-1:0] rx_fixed;
    dec_kind_t         rx_kind;
    logic              corr_evt;
    logic              fatal_evt;

    secded_dec #(.DATA_W(DATA_W), .HAM_W(HAM_W), .CHK_W(CHK_W)) u_rx_dec (
        .data_i  (rx_data_i),
        .chk_i   (rx_chk_i),
        .fixed_o (rx_fixed),
        .kind_o  (rx_kind)
    );

    assign corr_evt  = rx_valid_i && (rx_kind == DK_FIX_DATA || rx_kind == DK_FIX_CHK);
    assign fatal_evt = rx_valid_i && (rx_kind == DK_FATAL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid_o     <= 1'b0;
            rx_data_o      <= '0;
            rx_corrected_o <= 1'b0;
            rx_fatal_o     <= 1'b0;
        end else begin
            rx_valid_o     <= rx_valid_i;
            rx_data_o      <= rx_valid_i ? rx_fixed : '0;
            rx_corrected_o <= corr_evt;
            rx_fatal_o     <= fatal_evt;
        end
    end

    // ---------------- corrected-error counter ----------------
    secded_err_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (corr_evt),
        .idle_i (backend_idle_i),
        .snap_o (corr_count_o)
    );

    // ---------------- run / halt controller ----------------
    port_state_t state_q, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_RUN:  if (fatal_evt && !err_mask_i) state_nx = ST_HALT;
            ST_HALT: state_nx = ST_HALT;
            default: state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_HALT: halt_req_o = 1'b1;
            default: halt_req_o = 1'b0;
        endcase
    end

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt_req_o |=> halt_req_o); // R7
    AST_HALT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req_o) |-> rx_fatal_o); // R7
    AST_HALT_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req_o) |-> !$past(err_mask_i)); // R8
    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_corrected_o && rx_fatal_o)); // R4
    AST_FLAG_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_corrected_o || rx_fatal_o) |-> rx_valid_o); // R12

endmodule

// File: tb/secded_port_tb.sv
`timescale 1ns/1ps
module secded_port_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_mask_i = 1'b0;
    logic        backend_idle_i = 1'b0;
    logic        tx_valid_i = 1'b0;
    logic [31:0] tx_data_i = '0;
    logic        tx_valid_o;
    logic [31:0] tx_data_o;
    logic [6:0]  tx_chk_o;
    logic        rx_valid_i = 1'b0;
    logic [31:0] rx_data_i = '0;
    logic [6:0]  rx_chk_i = '0;
    logic        rx_valid_o;
    logic [31:0] rx_data_o;
    logic        rx_corrected_o;
    logic        rx_fatal_o;
    logic        halt_req_o;
    logic [7:0]  corr_count_o;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [33:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    secded_port u_dut (
        .clk(clk), .rst_n(rst_n), .err_mask_i(err_mask_i), .backend_idle_i(backend_idle_i),
        .tx_valid_i(tx_valid_i), .tx_data_i(tx_data_i),
        .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o), .tx_chk_o(tx_chk_o),
        .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i), .rx_chk_i(rx_chk_i),
        .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
        .rx_corrected_o(rx_corrected_o), .rx_fatal_o(rx_fatal_o),
        .halt_req_o(halt_req_o), .corr_count_o(corr_count_o)
    );

    // Reference code: walk positions 1..38, data fills the non-power-of-two ones
    function automatic logic [6:0] ref_chk(logic [31:0] d);
        logic [6:0] c;
        int n;
        c = '0;
        n = 0;
        for (int q = 1; q <= 38; q++) begin
            if ((q & (q - 1)) != 0) begin
                for (int k = 0; k < 6; k++) if (q[k]) c[k] = c[k] ^ d[n];
                n++;
            end
        end
        c[6] = (^d) ^ (^c[5:0]);
        return c;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tx_word(logic [31:0] d);
        @(negedge clk);
        tx_valid_i = 1'b1;
        tx_data_i  = d;
        @(negedge clk);
        tx_valid_i = 1'b0;
        check("R1 tx", {tx_valid_o, tx_chk_o, tx_data_o}, {1'b1, ref_chk(d), d});
    endtask

    // flip: bit i<32 flips data bit i, bit 32+k flips check bit k
    task automatic rx_word(string tag, logic [31:0] d, logic [38:0] flip,
                           logic exp_corr, logic exp_fatal);
        logic [38:0] w;
        w = {ref_chk(d), d} ^ flip;
        @(negedge clk);
        rx_valid_i = 1'b1;
        rx_data_i  = w[31:0];
        rx_chk_i   = w[38:32];
        exp_q.push_back({exp_fatal ? w[31:0] : d, exp_corr, exp_fatal});
        tag_q.push_back(tag);
    endtask

    task automatic rx_idle();
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rx_valid_o) begin
                if (exp_q.size() == 0) begin
                    check("R2 unexpected", {rx_data_o, rx_corrected_o, rx_fatal_o}, 64'h0);
                end else begin
                    logic [33:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, {rx_data_o, rx_corrected_o, rx_fatal_o}, e);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R2 watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        check("R11 reset", {tx_valid_o, tx_data_o, tx_chk_o, rx_valid_o, rx_corrected_o, rx_fatal_o,
                            halt_req_o, corr_count_o}, 64'h0);
        check("R11 rx_data", rx_data_o, 64'h0);

        // R1 encoding
        tx_word(32'h0000_0000);
        tx_word(32'hFFFF_FFFF);
        tx_word(32'hA5A5_5A5A);
        tx_word(32'h0000_0001);
        tx_word(32'h8000_0000);

        // R2 R3 clean words
        rx_word("R3 clean", 32'h1234_5678, 39'h0, 1'b0, 1'b0);
        rx_word("R3 clean", 32'hFFFF_FFFF, 39'h0, 1'b0, 1'b0);
        rx_word("R3 clean", 32'h0000_0000, 39'h0, 1'b0, 1'b0);
        rx_word("R2 clean", 32'hDEAD_BEEF, 39'h0, 1'b0, 1'b0);
        rx_idle();

        // R4 single data bit errors
        rx_word("R4 data0",  32'hCAFE_0001, 39'h1 << 0,  1'b1, 1'b0);
        rx_word("R4 data7",  32'h0F0F_0F0F, 39'h1 << 7,  1'b1, 1'b0);
        rx_word("R4 data15", 32'h7777_0000, 39'h1 << 15, 1'b1, 1'b0);
        rx_word("R4 data31", 32'h0000_0000, 39'h1 << 31, 1'b1, 1'b0);

        // R5 single check bit errors
        for (int k = 0; k < 7; k++) rx_word("R5 chkbit", 32'h3C3C_A0A0 + k, 39'h1 << (32 + k), 1'b1, 1'b0);
        rx_idle();
        rx_idle();

        // R10 snapshot frozen while busy
        check("R10 hold", corr_count_o, 64'd0);
        backend_idle_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 count", corr_count_o, 64'd11);

        // R12 invalid words ignored
        @(negedge clk);
        rx_data_i = 32'h0000_0005;
        rx_chk_i  = 7'h55;
        repeat (3) begin
            @(negedge clk);
            check("R12 no flag", {rx_valid_o, rx_corrected_o, rx_fatal_o}, 64'h0);
        end
        @(negedge clk);
        check("R12 no count", corr_count_o, 64'd11);

        // R6 R8 masked double errors
        err_mask_i = 1'b1;
        rx_word("R6 double", 32'h0BAD_F00D, (39'h1 << 3) | (39'h1 << 9), 1'b0, 1'b1);
        rx_word("R6 data+chk", 32'h5555_AAAA, (39'h1 << 0) | (39'h1 << 34), 1'b0, 1'b1);
        rx_idle();
        rx_idle();
        check("R8 no halt", halt_req_o, 64'd0);
        @(negedge clk);
        check("R9 fatal not counted", corr_count_o, 64'd11);

        // R9 saturation
        backend_idle_i = 1'b0;
        for (int n = 0; n < 250; n++) rx_word("R4 burst", 32'h1000_0000 + n, 39'h1 << (n % 32), 1'b1, 1'b0);
        rx_idle();
        backend_idle_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 saturate", corr_count_o, 64'd255);
        rx_word("R9 more", 32'h0000_00FF, 39'h1 << 36, 1'b1, 1'b0);
        rx_word("R9 more", 32'h0000_0F00, 39'h1 << 20, 1'b1, 1'b0);
        rx_idle();
        @(negedge clk);
        @(negedge clk);
        check("R9 stays max", corr_count_o, 64'd255);

        // R7 unmasked fatal
        err_mask_i = 1'b0;
        rx_word("R3 pre-halt", 32'h2468_ACE0, 39'h0, 1'b0, 1'b0);
        rx_idle();
        check("R7 not yet", halt_req_o, 64'd0);
        rx_word("R7 double", 32'h1357_9BDF, (39'h1 << 5) | (39'h1 << 6), 1'b0, 1'b1);
        rx_idle();
        check("R7 halt with flag", {halt_req_o, rx_fatal_o}, 64'h3);
        rx_word("R7 after", 32'h1111_2222, 39'h0, 1'b0, 1'b0);
        rx_word("R7 after", 32'h3333_4444, 39'h0, 1'b0, 1'b0);
        rx_idle();
        check("R7 sticky", halt_req_o, 64'd1);
        repeat (3) @(negedge clk);
        check("R7 sticky late", halt_req_o, 64'd1);
        check("R2 drained", exp_q.size(), 64'd0);
        finish_run();
    end

endmodule